// File: doc/BRIEF.md
# Reset Sequencing Controller

This block merges every reset request of a small microcontroller into one chip-wide reset. The requests are a power-on detect, an active-low external reset pin, a watchdog timeout and a brown-out detect that counts only while its enable input is high. A core sleep flag lets the block treat a watchdog timeout during sleep as a wake-up, which leaves register state untouched, instead of as a reset. Two status flags, timeout and power-down, and a cause code tell software which of six events happened last.

The block runs on the internal RC oscillator clock. After power-on or brown-out, it holds reset while a power-up counter runs on that clock. It then keeps holding reset while a start-up counter counts rising edges of the external clock pin. Pin and watchdog resets taken while the core is running skip both counters. They release as soon as the request goes away. The reset pin passes through a synchronizer and a low-level glitch filter before it is used.

Top module: `rst_sequencer`

## Requirements
- R1: While `porReq` is high, `chipReset` is 1, `statTo` is 1, `statPd` is 1 and `resetCause` is 0 (power-on).
- R2: After `porReq` falls, `chipReset` stays high for 1024 `clk` cycles and then for 1024 rising edges of `extClk`. It never releases while `extClk` is stopped.
- R3: `mclrN` is sampled through a two-stage synchronizer. A low level seen on fewer than 4 consecutive samples is ignored. A low level seen on 4 or more consecutive samples is a pin reset request.
- R4: A pin reset while `sleeping` is 0 holds `chipReset` high until the pin returns high, with no startup counters. It sets `resetCause` to 1 and leaves `statTo` and `statPd` unchanged.
- R5: A pin reset while `sleeping` is 1 asserts `chipReset` and sets `resetCause` to 2, `statTo` to 1 and `statPd` to 0.
- R6: A rising `wdtTimeout` while running (`sleeping` 0, not in reset) holds `chipReset` high until the timeout drops, with no startup counters. It sets `resetCause` to 3, `statTo` to 0 and `statPd` to 1.
- R7: A rising `wdtTimeout` while `sleeping` is 1 gives a single-cycle `wakeUp` pulse and no `chipReset`. It sets `resetCause` to 4, `statTo` to 0 and `statPd` to 0.
- R8: `bodDetect` with `bodEnable` high asserts `chipReset` and sets `resetCause` to 5, `statTo` to 1 and `statPd` to 1. Once the detect clears, both startup counters run again before release.
- R9: `bodDetect` while `bodEnable` is low has no effect on `chipReset`, the status flags or `resetCause`.
- R10: `resetCause` is always one of the six codes 0 to 5 listed in R1 and R4 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal RC oscillator clock |
| porReq | input | 1 | Power-on detect, active high, asynchronous |
| extClk | input | 1 | External clock pin, drives the start-up counter |
| mclrN | input | 1 | External reset pin, active low, asynchronous |
| wdtTimeout | input | 1 | Watchdog timeout level |
| bodDetect | input | 1 | Brown-out detect level |
| bodEnable | input | 1 | Brown-out reset enable |
| sleeping | input | 1 | Core is in sleep |
| chipReset | output | 1 | Chip-wide reset, active high |
| wakeUp | output | 1 | One-cycle wake strobe after a watchdog timeout in sleep |
| statTo | output | 1 | Timeout status flag |
| statPd | output | 1 | Power-down status flag |
| resetCause | output | 3 | Code of the last reset or wake event |

## Verification
The watchdog and the pin are each applied once with the core awake and once asleep. These pairs separate the reset from the wake-up and the two status encodings. The pin reset while awake comes right after a watchdog reset, so an unchanged flag pair differs from a freshly written one. Brown-out is applied with its enable low and then high, which shows the gating. Pin pulses of three and five cycles bracket the filter threshold. The power-on release is observed with the external clock stopped and then running, which shows that the two counters are cascaded.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

  typedef enum logic [2:0] {
    CAUSE_POR       = 3'd0,
    CAUSE_PIN_RUN   = 3'd1,
    CAUSE_PIN_SLEEP = 3'd2,
    CAUSE_WDT_RUN   = 3'd3,
    CAUSE_WDT_WAKE  = 3'd4,
    CAUSE_BROWNOUT  = 3'd5
  } cause_e;

  // control -> datapath
  typedef struct packed {
    logic pwrtClr;
    logic pwrtRun;
    logic ostClr;
    logic ostRun;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic pinReq;
    logic pinRise;
    logic wdtLvl;
    logic wdtRise;
    logic bodLvl;
    logic bodRise;
    logic pwrtDone;
    logic ostDone;
  } event_t;

endpackage

// File: rtl/rst_seq_datapath.sv
module rst_seq_datapath
  import rst_seq_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    extClk,
  input  logic    mclrN,
  input  logic    wdtTimeout,
  input  logic    bodDetect,
  input  logic    bodEnable,
  input  strobe_t stb,
  output event_t  evt
);

  localparam int FW = $clog2(FILT_LEN + 1);
  localparam logic [FW-1:0]    FILT_MAX = FW'(FILT_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [SYNC_STAGES-1:0] pinSync;
  logic [SYNC_STAGES:0]   extSync;
  logic [FW-1:0]          lowCnt;
  logic [CNT_W-1:0]       pwrtCnt;
  logic [CNT_W-1:0]       ostCnt;
  logic pinReqQ, wdtQ, bodQ;
  logic pinReq, bodLvl, extRise;

  // synchronizers for the two asynchronous pins
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pinSync <= '1;
      extSync <= '0;
    end else begin
      pinSync <= {pinSync[SYNC_STAGES-2:0], mclrN};
      extSync <= {extSync[SYNC_STAGES-1:0], extClk};
    end
  end

  assign extRise = extSync[SYNC_STAGES-1] & ~extSync[SYNC_STAGES];

  // low-level glitch filter on the reset pin
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                       lowCnt <= '0;
    else if (pinSync[SYNC_STAGES-1]) lowCnt <= '0;
    else if (lowCnt != FILT_MAX)   lowCnt <= lowCnt + 1'b1;
  end

  assign pinReq = (lowCnt == FILT_MAX);
  assign bodLvl = bodDetect & bodEnable;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      pinReqQ <= 1'b0;
      wdtQ    <= 1'b0;
      bodQ    <= 1'b0;
    end else begin
      pinReqQ <= pinReq;
      wdtQ    <= wdtTimeout;
      bodQ    <= bodLvl;
    end
  end

  // power-up counter on the RC clock
  always_ff @(posedge clk or posedge rst) begin
    if (rst)              pwrtCnt <= '0;
    else if (stb.pwrtClr) pwrtCnt <= '0;
    else if (stb.pwrtRun) pwrtCnt <= pwrtCnt + 1'b1;
  end

  // start-up counter on external clock edges
  always_ff @(posedge clk or posedge rst) begin
    if (rst)                        ostCnt <= '0;
    else if (stb.ostClr)            ostCnt <= '0;
    else if (stb.ostRun && extRise) ostCnt <= ostCnt + 1'b1;
  end

  always_comb begin
    evt.pinReq   = pinReq;
    evt.pinRise  = pinReq & ~pinReqQ;
    evt.wdtLvl   = wdtTimeout;
    evt.wdtRise  = wdtTimeout & ~wdtQ;
    evt.bodLvl   = bodLvl;
    evt.bodRise  = bodLvl & ~bodQ;
    evt.pwrtDone = stb.pwrtRun && !stb.pwrtClr && (pwrtCnt == CNT_MAX);
    evt.ostDone  = stb.ostRun && !stb.ostClr && extRise && (ostCnt == CNT_MAX);
  end

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
  import rst_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    sleeping,
  input  event_t  evt,
  output strobe_t stb,
  output logic    chipReset,
  output logic    wakeUp,
  output logic    statTo,
  output logic    statPd,
  output cause_e  cause
);

  typedef enum logic [1:0] {ST_RUN, ST_HOLD, ST_PWRT, ST_OST} state_e;
  state_e state;
  logic inTimers;

  assign inTimers = (state == ST_PWRT) || (state == ST_OST);

  always_comb begin
    stb.pwrtRun = (state == ST_PWRT);
    stb.pwrtClr = (state != ST_PWRT) || evt.bodLvl || evt.pinReq;
    stb.ostRun  = (state == ST_OST);
    stb.ostClr  = (state != ST_OST);
  end

  // chipReset behaves as a set/reset latch: sources set, timeouts clear
  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state     <= ST_PWRT;
      chipReset <= 1'b1;
      wakeUp    <= 1'b0;
      statTo    <= 1'b1;
      statPd    <= 1'b1;
      cause     <= CAUSE_POR;
    end else begin
      wakeUp <= 1'b0;
      if (evt.bodLvl) begin
        state     <= ST_PWRT;
        chipReset <= 1'b1;
        if (evt.bodRise) begin
          cause  <= CAUSE_BROWNOUT;
          statTo <= 1'b1;
          statPd <= 1'b1;
        end
      end else if (evt.pinReq) begin
        state     <= inTimers ? ST_PWRT : ST_HOLD;
        chipReset <= 1'b1;
        if (evt.pinRise) begin
          if (sleeping) begin
            cause  <= CAUSE_PIN_SLEEP;
            statTo <= 1'b1;
            statPd <= 1'b0;
          end else begin
            cause  <= CAUSE_PIN_RUN;
          end
        end
      end else if (evt.wdtRise && state == ST_RUN) begin
        statTo <= 1'b0;
        if (sleeping) begin
          wakeUp <= 1'b1;
          statPd <= 1'b0;
          cause  <= CAUSE_WDT_WAKE;
        end else begin
          state     <= ST_HOLD;
          chipReset <= 1'b1;
          statPd    <= 1'b1;
          cause     <= CAUSE_WDT_RUN;
        end
      end else begin
        unique case (state)
          ST_HOLD: if (!evt.wdtLvl) begin
            state     <= ST_RUN;
            chipReset <= 1'b0;
          end
          ST_PWRT: if (evt.pwrtDone) state <= ST_OST;
          ST_OST: if (evt.ostDone) begin
            state     <= ST_RUN;
            chipReset <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_seq_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int FILT_LEN    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porReq,
  input  logic       extClk,
  input  logic       mclrN,
  input  logic       wdtTimeout,
  input  logic       bodDetect,
  input  logic       bodEnable,
  input  logic       sleeping,
  output logic       chipReset,
  output logic       wakeUp,
  output logic       statTo,
  output logic       statPd,
  output logic [2:0] resetCause
);

  strobe_t stb;
  event_t  evt;
  cause_e  cause;

  rst_seq_datapath #(
    .CNT_W(CNT_W), .FILT_LEN(FILT_LEN), .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk(clk), .rst(porReq), .extClk(extClk), .mclrN(mclrN),
    .wdtTimeout(wdtTimeout), .bodDetect(bodDetect), .bodEnable(bodEnable),
    .stb(stb), .evt(evt)
  );

  rst_seq_ctrl ctrl_i (
    .clk(clk), .rst(porReq), .sleeping(sleeping), .evt(evt), .stb(stb),
    .chipReset(chipReset), .wakeUp(wakeUp), .statTo(statTo),
    .statPd(statPd), .cause(cause)
  );

  assign resetCause = cause;

endmodule

// File: rtl/rst_sequencer_checker.sv
module rst_sequencer_checker (
  input logic       clk,
  input logic       porReq,
  input logic       bodEnable,
  input logic       chipReset,
  input logic       wakeUp,
  input logic       statTo,
  input logic       statPd,
  input logic [2:0] resetCause
);

  AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (porReq)
    resetCause <= 3'd5); // R10

  AST_WAKE_NO_RESET: assert property (@(posedge clk) disable iff (porReq)
    wakeUp |-> !chipReset); // R7

  AST_WAKE_STATUS: assert property (@(posedge clk) disable iff (porReq)
    wakeUp |-> (!statTo && !statPd && resetCause == 3'd4)); // R7

  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (porReq)
    wakeUp |=> !wakeUp); // R7

  AST_WDT_RUN_STATUS: assert property (@(posedge clk) disable iff (porReq)
    ($rose(chipReset) && resetCause == 3'd3) |-> (!statTo && statPd)); // R6

  AST_PIN_SLEEP_STATUS: assert property (@(posedge clk) disable iff (porReq)
    ($rose(chipReset) && resetCause == 3'd2) |-> (statTo && !statPd)); // R5

  AST_BOD_STATUS: assert property (@(posedge clk) disable iff (porReq)
    ($rose(chipReset) && resetCause == 3'd5) |-> (statTo && statPd)); // R8

  AST_BOD_GATED: assert property (@(posedge clk) disable iff (porReq)
    ($rose(chipReset) && resetCause == 3'd5) |-> $past(bodEnable)); // R9

endmodule

bind rst_sequencer rst_sequencer_checker chk_i (
  .clk(clk), .porReq(porReq), .bodEnable(bodEnable), .chipReset(chipReset),
  .wakeUp(wakeUp), .statTo(statTo), .statPd(statPd), .resetCause(resetCause)
);

// File: tb/rst_sequencer_tb_top.sv
module rst_sequencer_tb_top;

  logic clk = 1'b0;
  logic extClk = 1'b0;
  logic extRun = 1'b0;
  logic porReq, mclrN, wdtTimeout, bodDetect, bodEnable, sleeping;
  logic chipReset, wakeUp, statTo, statPd;
  logic [2:0] resetCause;

  int errors = 0;
  int checks = 0;
  int wakeCnt = 0;
  bit rstSeen = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  initial begin
    #5;
    forever begin
      #20;
      if (extRun) extClk = ~extClk;
    end
  end

  rst_sequencer dut_i (
    .clk(clk), .porReq(porReq), .extClk(extClk), .mclrN(mclrN),
    .wdtTimeout(wdtTimeout), .bodDetect(bodDetect), .bodEnable(bodEnable),
    .sleeping(sleeping), .chipReset(chipReset), .wakeUp(wakeUp),
    .statTo(statTo), .statPd(statPd), .resetCause(resetCause)
  );

  always @(negedge clk) begin
    if (wakeUp) wakeCnt++;
    if (chipReset) rstSeen = 1'b1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {kind[1:0], sleep, expTo, expPd, expCause[2:0], expRst}
  // kind: 0 watchdog, 1 pin, 2 brown-out enabled, 3 brown-out disabled
  localparam logic [8:0] VEC [6] = '{
    {2'd0, 1'b0, 1'b0, 1'b1, 3'd3, 1'b1},  // R6 watchdog while running
    {2'd1, 1'b0, 1'b0, 1'b1, 3'd1, 1'b1},  // R4 pin while running, flags kept
    {2'd0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b0},  // R7 watchdog wake from sleep
    {2'd1, 1'b1, 1'b1, 1'b0, 3'd2, 1'b1},  // R5 pin during sleep
    {2'd3, 1'b0, 1'b1, 1'b0, 3'd2, 1'b0},  // R9 brown-out while disabled
    {2'd2, 1'b0, 1'b1, 1'b1, 3'd5, 1'b1}   // R8 brown-out enabled
  };

  function automatic string tagOf(input logic [1:0] kind, input logic slp);
    case (kind)
      2'd0: return slp ? "R7" : "R6";
      2'd1: return slp ? "R5" : "R4";
      2'd2: return "R8";
      default: return "R9";
    endcase
  endfunction

  initial begin
    porReq = 1'b1; mclrN = 1'b1; wdtTimeout = 1'b0;
    bodDetect = 1'b0; bodEnable = 1'b0; sleeping = 1'b0;
    cycles(5);
    check(chipReset == 1'b1, "R1", "chipReset in power-on", int'(chipReset), 1);
    check(statTo == 1'b1, "R1", "statTo in power-on", int'(statTo), 1);
    check(statPd == 1'b1, "R1", "statPd in power-on", int'(statPd), 1);
    check(resetCause == 3'd0, "R10", "cause code power-on", int'(resetCause), 0);

    porReq = 1'b0;
    cycles(1500);
    check(chipReset == 1'b1, "R2", "held with ext clock stopped", int'(chipReset), 1);
    extRun = 1'b1;
    cycles(1900);
    check(chipReset == 1'b1, "R2", "held before start-up count ends", int'(chipReset), 1);
    cycles(300);
    check(chipReset == 1'b0, "R2", "released after both counters", int'(chipReset), 0);

    // glitch shorter than the filter
    rstSeen = 1'b0;
    mclrN = 1'b0; cycles(3); mclrN = 1'b1; cycles(12);
    check(rstSeen == 1'b0, "R3", "3-sample glitch ignored", int'(rstSeen), 0);
    check(resetCause == 3'd0, "R3", "cause after glitch", int'(resetCause), 0);

    // table of reset and wake events
    for (int i = 0; i < 6; i++) begin
      logic [1:0] kind;
      logic slp;
      string tag;
      kind = VEC[i][8:7];
      slp  = VEC[i][6];
      tag  = tagOf(kind, slp);
      wakeCnt = 0;
      rstSeen = 1'b0;
      sleeping = slp;
      case (kind)
        2'd0: wdtTimeout = 1'b1;
        2'd1: mclrN = 1'b0;
        2'd2: begin bodEnable = 1'b1; bodDetect = 1'b1; end
        default: begin bodEnable = 1'b0; bodDetect = 1'b1; end
      endcase
      cycles(20);
      check(chipReset == VEC[i][0], tag, "chipReset during event", int'(chipReset), int'(VEC[i][0]));
      check(statTo == VEC[i][5], tag, "statTo", int'(statTo), int'(VEC[i][5]));
      check(statPd == VEC[i][4], tag, "statPd", int'(statPd), int'(VEC[i][4]));
      check(resetCause == VEC[i][3:1], tag, "resetCause", int'(resetCause), int'(VEC[i][3:1]));
      check(wakeCnt == ((kind == 2'd0 && slp) ? 1 : 0), tag, "wake pulses",
            wakeCnt, (kind == 2'd0 && slp) ? 1 : 0);
      if (!VEC[i][0])
        check(rstSeen == 1'b0, tag, "no reset seen", int'(rstSeen), 0);
      mclrN = 1'b1; wdtTimeout = 1'b0; bodDetect = 1'b0; sleeping = 1'b0;
      if (kind == 2'd2) begin
        cycles(500);
        check(chipReset == 1'b1, "R8", "startup counters rerun", int'(chipReset), 1);
        cycles(3500);
      end else begin
        cycles(12);
      end
      check(chipReset == 1'b0, tag, "released after event", int'(chipReset), 0);
    end
    bodEnable = 1'b0;

    // pulse just above the filter length
    rstSeen = 1'b0;
    mclrN = 1'b0; cycles(5); mclrN = 1'b1; cycles(12);
    check(rstSeen == 1'b1, "R3", "5-sample low accepted", int'(rstSeen), 1);
    check(resetCause == 3'd1, "R4", "cause after short pin reset", int'(resetCause), 1);
    check(chipReset == 1'b0, "R4", "release without counters", int'(chipReset), 0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule